// File: doc/BRIEF.md
# Two-Wire EEPROM Power-Up Configuration Loader

This block runs once after every hardware reset. It acts as the only master on a two-wire serial EEPROM bus. It drives the clock line and pulls the open-drain data line low, and it reads a short configuration record from address zero of the memory. It sends a start condition, the device-select byte for a write, and the byte address 0x00. It then sends a repeated start and the device-select byte for a read, reads seven bytes in a row and finishes with a stop condition.

The first byte read is a signature. The configuration is only taken if the signature equals a parameter value. If it is good, the next four bytes form the subsystem vendor identifier and the subsystem identifier. The last two bytes are two general configuration bytes. All of them reach the outputs in one cycle, together with two load strobes. If no device answers, the loader reports the memory as absent. If the signature is wrong, it reports the record as invalid. In both of these cases the outputs stay at zero. Each phase of the clock lasts at least two `QTR_CYC` periods, so a slow memory can be matched by changing that parameter.

Top module: `eeprom_boot_loader`

## Requirements
- R1: While reset is low, every output is zero except `scl_o`, which is 1. The first bus action, pulling `scl_o` low to begin the start condition, happens within two clock cycles after reset is released, with no other input needed.
- R2: The data line (`sda_oe_o`) changes while `scl_o` is high only to form a start condition (data falls) or a stop condition (data rises).
- R3: Every low phase of `scl_o` lasts at least 2*QTR_CYC clock cycles. Every high phase except the one that ends reset also lasts at least 2*QTR_CYC cycles.
- R4: The bus sequence is as follows:
  - start, then device byte `{4'b1010, BANK_SEL, 1'b0}`, then byte address 0x00;
  - repeated start, then device byte `{4'b1010, BANK_SEL, 1'b1}`;
  - seven bytes read, MSB first;
  - one stop.
- R5: The loader drives an acknowledge (data low) after read bytes 1 to 6. It leaves the data line released (no acknowledge) after byte 7.
- R6: If any of the three address bytes is not acknowledged, the loader sends a stop and then ends. It sets `done_o` and `absent_o`, and it leaves the identifier and configuration outputs at zero with no load strobe.
- R7: If read byte 1 differs from `SIG_BYTE`, the loader does not acknowledge it. It then sends a stop and reads nothing more. It sets `done_o` and `invalid_o`, and it loads nothing.
- R8: On success, the outputs take these values:
  - `subsys_vendor_o` = {byte3, byte2};
  - `subsys_id_o` = {byte5, byte4};
  - `cfg_a_o` = byte6 and `cfg_b_o` = byte7.
  `id_load_o` and `cfg_load_o` each pulse high for one cycle, exactly once, in the first cycle in which `done_o` is high. Byte1 is the signature.
- R9: After `done_o` rises, `absent_o` and `invalid_o` are never both set. No further bus activity follows: `scl_o` stays at 1 and `sda_oe_o` stays at 0. The outputs hold their values until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_o | output | 1 | Serial clock to the EEPROM |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| sda_i | input | 1 | Level sensed on the data line |
| subsys_vendor_o | output | 16 | Loaded subsystem vendor identifier |
| subsys_id_o | output | 16 | Loaded subsystem identifier |
| cfg_a_o | output | 8 | First general configuration byte |
| cfg_b_o | output | 8 | Second general configuration byte |
| id_load_o | output | 1 | One-cycle strobe: identifier outputs valid |
| cfg_load_o | output | 1 | One-cycle strobe: configuration bytes valid |
| done_o | output | 1 | Loader has finished |
| absent_o | output | 1 | No acknowledge to an address byte |
| invalid_o | output | 1 | Signature byte did not match |

## Verification
The assertions check four rules on every cycle:
- the data line stays still while the clock is high, except during start and stop symbols;
- every low phase of the clock meets its minimum length;
- the load strobes appear only with a successful finish, and never twice in a row;
- the bus is idle and the status bits do not conflict once the loader has finished.

Only the bench's scenarios can show the rest. A behavioural EEPROM model on the bus checks the exact byte sequence, the acknowledge pattern on reads, the byte-to-field mapping, and the three outcomes. These outcomes come from a missing device, a wrong bank select and a bad signature, mixed with randomly filled memory contents.

// File: rtl/eeb_pkg.sv
// Package: shared types for the EEPROM boot loader.
// Assumes: one bit symbol is issued at a time to the bit engine.
package eeb_pkg;

    // Bus symbol kinds handled by the bit engine
    typedef enum logic [1:0] {
        SYM_START = 2'd0,
        SYM_STOP  = 2'd1,
        SYM_WBIT  = 2'd2,
        SYM_RBIT  = 2'd3
    } sym_e;

    // Top-level sequence states
    typedef enum logic [2:0] {
        ST_START1 = 3'd0,
        ST_WBYTE  = 3'd1,
        ST_RSTART = 3'd2,
        ST_RBYTE  = 3'd3,
        ST_STOP   = 3'd4,
        ST_FIN    = 3'd5
    } seq_e;

    // Outcome of the transfer
    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_ABSENT  = 2'd1,
        RES_INVALID = 2'd2
    } res_e;

endpackage

// File: rtl/eeb_bit_engine.sv
// Module: eeb_bit_engine
// Turns one symbol (start, stop, write bit, read bit) into clock/data
// waveforms. Each symbol has four quarters of QTR_CYC cycles:
// q0 clock low, q1 data set, q2 clock high, q3 (start/stop edge).
// Assumes: a new command is offered only while the engine is idle.
module eeb_bit_engine
    import eeb_pkg::*;
#(
    parameter int QTR_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  sym_e cmd,
    input  logic cmd_bit,
    input  logic sda_i,
    output logic done_o,
    output logic rbit_o,
    output logic scl_o,
    output logic sda_oe_o
);
    localparam int CW = $clog2(QTR_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(QTR_CYC - 1);

    logic          active;
    logic [1:0]    ph;
    logic [CW-1:0] cnt;
    sym_e          cur;
    logic          wbit;

    // Quarter sequencer: steps the phases and drives the line registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            ph       <= 2'd0;
            cnt      <= '0;
            cur      <= SYM_STOP;
            wbit     <= 1'b0;
            scl_o    <= 1'b1;
            sda_oe_o <= 1'b0;
            done_o   <= 1'b0;
            rbit_o   <= 1'b1;
        end else begin
            done_o <= 1'b0;
            if (!active) begin
                if (cmd_valid) begin
                    active <= 1'b1;
                    ph     <= 2'd0;
                    cnt    <= '0;
                    cur    <= cmd;
                    wbit   <= cmd_bit;
                    scl_o  <= 1'b0;
                end
            end else if (cnt == CNT_LAST) begin
                cnt <= '0;
                if (ph == 2'd3) begin
                    active <= 1'b0;
                    done_o <= 1'b1;
                    rbit_o <= sda_i;
                end else begin
                    ph <= ph + 2'd1;
                    case (ph)
                        2'd0: begin
                            case (cur)
                                SYM_START: sda_oe_o <= 1'b0;
                                SYM_STOP:  sda_oe_o <= 1'b1;
                                SYM_WBIT:  sda_oe_o <= ~wbit;
                                default:   sda_oe_o <= 1'b0;
                            endcase
                        end
                        2'd1: scl_o <= 1'b1;
                        default: begin
                            if (cur == SYM_START) sda_oe_o <= 1'b1;
                            else if (cur == SYM_STOP) sda_oe_o <= 1'b0;
                        end
                    endcase
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Low-phase length counter for the timing check
    logic [15:0] low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) low_cnt <= '0;
        else        low_cnt <= scl_o ? 16'd0 : low_cnt + 16'd1;
    end

    a_r2_sda_still_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (cur == SYM_WBIT || cur == SYM_RBIT)) |-> $stable(sda_oe_o));

    a_r3_min_low_time: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> (low_cnt >= 16'(2 * QTR_CYC)));

endmodule

// File: rtl/eeb_sequencer.sv
// Module: eeb_sequencer
// Walks the random-read transfer byte by byte, checks the signature,
// stages the data bytes and commits them at the end only on success.
// Assumes: bit_done pulses once per issued symbol; rbit valid with it.
module eeb_sequencer
    import eeb_pkg::*;
#(
    parameter logic [2:0] BANK_SEL = 3'b000,
    parameter logic [7:0] SIG_BYTE = 8'hA5,
    parameter int         N_BYTES  = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_done,
    input  logic        rbit,
    output logic        cmd_valid,
    output sym_e        cmd,
    output logic        cmd_bit,
    output logic [15:0] subsys_vendor_o,
    output logic [15:0] subsys_id_o,
    output logic [7:0]  cfg_a_o,
    output logic [7:0]  cfg_b_o,
    output logic        id_load_o,
    output logic        cfg_load_o,
    output logic        done_o,
    output logic        absent_o,
    output logic        invalid_o
);
    localparam int          NDATA = N_BYTES - 1;
    localparam logic [2:0]  LAST  = 3'(N_BYTES - 1);

    seq_e                  st;
    res_e                  res;
    logic                  waiting;
    logic [3:0]            bitn;
    logic [1:0]            wsel;
    logic [2:0]            ridx;
    logic [7:0]            shreg;
    logic [NDATA-1:0][7:0] stage;
    logic [7:0]            tx_byte;
    logic                  hdr_bad;
    logic                  nack_rd;

    // Byte to send for the current address phase
    always_comb begin
        case (wsel)
            2'd0:    tx_byte = {4'b1010, BANK_SEL, 1'b0};
            2'd1:    tx_byte = 8'h00;
            default: tx_byte = {4'b1010, BANK_SEL, 1'b1};
        endcase
    end

    assign hdr_bad = (ridx == 3'd0) && (shreg != SIG_BYTE);
    assign nack_rd = (ridx == LAST) || hdr_bad;

    // Symbol request to the bit engine
    always_comb begin
        cmd_valid = !waiting && (st != ST_FIN);
        cmd       = SYM_START;
        cmd_bit   = 1'b1;
        case (st)
            ST_WBYTE: begin
                cmd     = (bitn < 4'd8) ? SYM_WBIT : SYM_RBIT;
                cmd_bit = tx_byte[3'd7 - bitn[2:0]];
            end
            ST_RBYTE: begin
                cmd     = (bitn < 4'd8) ? SYM_RBIT : SYM_WBIT;
                cmd_bit = nack_rd;
            end
            ST_STOP: cmd = SYM_STOP;
            default: cmd = SYM_START;
        endcase
    end

    // Transfer state, staging and result commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st              <= ST_START1;
            res             <= RES_OK;
            waiting         <= 1'b0;
            bitn            <= 4'd0;
            wsel            <= 2'd0;
            ridx            <= 3'd0;
            shreg           <= 8'h00;
            stage           <= '0;
            subsys_vendor_o <= 16'h0;
            subsys_id_o     <= 16'h0;
            cfg_a_o         <= 8'h0;
            cfg_b_o         <= 8'h0;
            id_load_o       <= 1'b0;
            cfg_load_o      <= 1'b0;
            done_o          <= 1'b0;
            absent_o        <= 1'b0;
            invalid_o       <= 1'b0;
        end else begin
            id_load_o  <= 1'b0;
            cfg_load_o <= 1'b0;
            if (cmd_valid) begin
                waiting <= 1'b1;
            end else if (waiting && bit_done) begin
                waiting <= 1'b0;
                case (st)
                    ST_START1: begin
                        st   <= ST_WBYTE;
                        wsel <= 2'd0;
                        bitn <= 4'd0;
                    end
                    ST_RSTART: begin
                        st   <= ST_WBYTE;
                        wsel <= 2'd2;
                        bitn <= 4'd0;
                    end
                    ST_WBYTE: begin
                        if (bitn < 4'd8) begin
                            bitn <= bitn + 4'd1;
                        end else if (rbit) begin
                            res <= RES_ABSENT;
                            st  <= ST_STOP;
                        end else begin
                            bitn <= 4'd0;
                            case (wsel)
                                2'd0:    wsel <= 2'd1;
                                2'd1:    st   <= ST_RSTART;
                                default: begin
                                    st   <= ST_RBYTE;
                                    ridx <= 3'd0;
                                end
                            endcase
                        end
                    end
                    ST_RBYTE: begin
                        if (bitn < 4'd8) begin
                            shreg <= {shreg[6:0], rbit};
                            bitn  <= bitn + 4'd1;
                        end else begin
                            bitn <= 4'd0;
                            if (ridx != 3'd0) stage[ridx - 3'd1] <= shreg;
                            if (hdr_bad) begin
                                res <= RES_INVALID;
                                st  <= ST_STOP;
                            end else if (ridx == LAST) begin
                                st <= ST_STOP;
                            end else begin
                                ridx <= ridx + 3'd1;
                            end
                        end
                    end
                    ST_STOP: begin
                        st        <= ST_FIN;
                        done_o    <= 1'b1;
                        absent_o  <= (res == RES_ABSENT);
                        invalid_o <= (res == RES_INVALID);
                        if (res == RES_OK) begin
                            subsys_vendor_o <= {stage[1], stage[0]};
                            subsys_id_o     <= {stage[3], stage[2]};
                            cfg_a_o         <= stage[4];
                            cfg_b_o         <= stage[5];
                            id_load_o       <= 1'b1;
                            cfg_load_o      <= 1'b1;
                        end
                    end
                    default: st <= ST_FIN;
                endcase
            end
        end
    end

    a_r8_load_only_on_success: assert property (@(posedge clk) disable iff (!rst_n)
        (id_load_o || cfg_load_o) |-> (done_o && !absent_o && !invalid_o));

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        id_load_o |=> !id_load_o);

endmodule

// File: rtl/eeprom_boot_loader.sv
// Module: eeprom_boot_loader (top)
// Reads the power-up configuration record from a two-wire EEPROM once
// after reset and presents the identifiers and configuration bytes.
// Assumes: an external pull-up on the data line; sole master on the bus.
module eeprom_boot_loader
    import eeb_pkg::*;
#(
    parameter int         QTR_CYC  = 4,
    parameter logic [2:0] BANK_SEL = 3'b000,
    parameter logic [7:0] SIG_BYTE = 8'hA5
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        scl_o,
    output logic        sda_oe_o,
    input  logic        sda_i,
    output logic [15:0] subsys_vendor_o,
    output logic [15:0] subsys_id_o,
    output logic [7:0]  cfg_a_o,
    output logic [7:0]  cfg_b_o,
    output logic        id_load_o,
    output logic        cfg_load_o,
    output logic        done_o,
    output logic        absent_o,
    output logic        invalid_o
);
    logic cmd_valid;
    sym_e cmd;
    logic cmd_bit;
    logic bit_done;
    logic rbit;

    eeb_bit_engine #(.QTR_CYC(QTR_CYC)) u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd      (cmd),
        .cmd_bit  (cmd_bit),
        .sda_i    (sda_i),
        .done_o   (bit_done),
        .rbit_o   (rbit),
        .scl_o    (scl_o),
        .sda_oe_o (sda_oe_o)
    );

    eeb_sequencer #(.BANK_SEL(BANK_SEL), .SIG_BYTE(SIG_BYTE), .N_BYTES(7)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_done       (bit_done),
        .rbit           (rbit),
        .cmd_valid      (cmd_valid),
        .cmd            (cmd),
        .cmd_bit        (cmd_bit),
        .subsys_vendor_o(subsys_vendor_o),
        .subsys_id_o    (subsys_id_o),
        .cfg_a_o        (cfg_a_o),
        .cfg_b_o        (cfg_b_o),
        .id_load_o      (id_load_o),
        .cfg_load_o     (cfg_load_o),
        .done_o         (done_o),
        .absent_o       (absent_o),
        .invalid_o      (invalid_o)
    );

    a_r9_bus_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (scl_o && !sda_oe_o));

    a_r9_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(absent_o && invalid_o));

endmodule

// File: tb/test_eeprom_boot_loader.sv
// Bench: behavioural EEPROM on the bus, directed and random scenarios.
module test_eeprom_boot_loader;
    localparam int         QTR = 4;
    localparam logic [2:0] BNK = 3'b000;
    localparam logic [7:0] SIG = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        scl, sda_oe, s_pull, sda_line;
    logic [15:0] svid, sid;
    logic [7:0]  cfa, cfb;
    logic        id_ld, cf_ld, done, absent, invalid;

    assign sda_line = ~(sda_oe | s_pull);

    eeprom_boot_loader i_eeprom_boot_loader (
        .clk(clk), .rst_n(rst_n), .scl_o(scl), .sda_oe_o(sda_oe), .sda_i(sda_line),
        .subsys_vendor_o(svid), .subsys_id_o(sid), .cfg_a_o(cfa), .cfg_b_o(cfb),
        .id_load_o(id_ld), .cfg_load_o(cf_ld), .done_o(done),
        .absent_o(absent), .invalid_o(invalid)
    );

    int n_checks = 0, n_err = 0;
    int cyc = 0;

    // slave model state and bus statistics
    logic [7:0] mem [8];
    bit         present;
    logic [2:0] sl_bank;
    bit ps, pd, rw, mack;
    int ph, bc, ptr;
    logic [7:0] sh;
    int n_start, n_stop, n_rd, n_mack, dev_w, dev_r, waddr;
    int low_run, high_run, min_low, min_high, fall_cyc, id_pulses, cf_pulses, bad_pulse;
    bit seen_fall;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            s_pull = 1'b0; ps = 1'b1; pd = 1'b1; ph = 0; bc = 0; ptr = 0; sh = 8'h0;
            rw = 1'b0; mack = 1'b0;
            n_start = 0; n_stop = 0; n_rd = 0; n_mack = 0; dev_w = 0; dev_r = 0; waddr = -1;
            low_run = 0; high_run = 0; min_low = 1 << 30; min_high = 1 << 30;
            seen_fall = 1'b0; fall_cyc = -1; id_pulses = 0; cf_pulses = 0; bad_pulse = 0;
        end else begin
            if (id_ld) begin id_pulses++; if (!done) bad_pulse++; end
            if (cf_ld) begin cf_pulses++; if (!done) bad_pulse++; end
            if (scl && ps && pd && !sda_line) begin
                n_start++; ph = 1; bc = 0; s_pull = 1'b0;
            end else if (scl && ps && !pd && sda_line) begin
                n_stop++; ph = 0; s_pull = 1'b0;
            end else if (scl && !ps) begin
                if (low_run < min_low) min_low = low_run;
                low_run = 0;
                if ((ph == 1 || ph == 2) && bc < 8) sh = {sh[6:0], sda_line};
                if (ph == 3 && bc == 8) begin
                    mack = !sda_line; n_rd++;
                    if (mack) n_mack++;
                end
                if (ph >= 1 && ph <= 3) bc++;
            end else if (!scl && ps) begin
                if (seen_fall && high_run < min_high) min_high = high_run;
                if (!seen_fall) fall_cyc = cyc;
                seen_fall = 1'b1;
                high_run = 0;
                if (ph == 1 || ph == 2) begin
                    if (bc == 8) begin
                        if (ph == 1) begin
                            if (present && sh[7:1] == {4'b1010, sl_bank}) begin
                                s_pull = 1'b1; rw = sh[0];
                                if (rw) dev_r++; else dev_w++;
                            end else begin
                                ph = 0;
                            end
                        end else begin
                            s_pull = 1'b1; ptr = int'(sh); waddr = int'(sh);
                        end
                    end else if (bc == 9) begin
                        s_pull = 1'b0; bc = 0;
                        if (ph == 1) begin
                            if (rw) begin ph = 3; s_pull = !mem[ptr % 8][7]; end
                            else ph = 2;
                        end else ph = 4;
                    end
                end else if (ph == 3) begin
                    if (bc < 8) s_pull = !mem[ptr % 8][7 - bc];
                    else if (bc == 8) s_pull = 1'b0;
                    else begin
                        if (mack) begin ptr++; bc = 0; s_pull = !mem[ptr % 8][7]; end
                        else begin s_pull = 1'b0; ph = 4; end
                    end
                end
            end
            if (scl) high_run++; else low_run++;
            ps = scl; pd = sda_line;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input bit pres, input logic [2:0] bank, input bit hdr_good);
        bit ok, abs_e, inv_e;
        int rel, waited, starts_then;
        logic [15:0] svid_then;
        for (int i = 0; i < 8; i++) mem[i] = 8'($urandom);
        if (hdr_good) mem[0] = SIG;
        else if (mem[0] == SIG) mem[0] = SIG ^ 8'h01;
        present = pres; sl_bank = bank;
        abs_e = !(pres && bank == BNK);
        inv_e = !abs_e && !hdr_good;
        ok    = !abs_e && !inv_e;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "done in reset", {31'b0, done}, 0);
        chk("R1", "scl in reset", {31'b0, scl}, 1);
        chk("R1", "ids in reset", {svid, sid}, 0);
        chk("R1", "status in reset", {29'b0, sda_oe, absent, invalid}, 0);
        rst_n = 1'b1; rel = cyc;
        waited = 0;
        while (!done && waited < 20000) begin @(negedge clk); waited++; end
        chk("R6", "finished", {31'b0, done}, 1);
        repeat (20) @(negedge clk);
        chk("R1", "first clock fall delay", {31'b0, (fall_cyc - rel) <= 2}, 1);
        chk("R6", "absent flag", {31'b0, absent}, {31'b0, abs_e});
        chk("R7", "invalid flag", {31'b0, invalid}, {31'b0, inv_e});
        chk("R4", "start count", n_start, abs_e ? 1 : 2);
        chk("R4", "stop count", n_stop, 1);
        chk("R3", "min low time", {31'b0, min_low >= 2 * QTR}, 1);
        chk("R3", "min high time", {31'b0, min_high >= 2 * QTR}, 1);
        if (!abs_e) begin
            chk("R4", "write select seen", dev_w, 1);
            chk("R4", "byte address", waddr, 0);
            chk("R4", "read select seen", dev_r, 1);
        end
        if (ok) begin
            chk("R8", "vendor id", {16'b0, svid}, {16'b0, mem[2], mem[1]});
            chk("R8", "subsystem id", {16'b0, sid}, {16'b0, mem[4], mem[3]});
            chk("R8", "cfg bytes", {16'b0, cfa, cfb}, {16'b0, mem[5], mem[6]});
            chk("R8", "strobe counts", {id_pulses[15:0], cf_pulses[15:0]}, {16'd1, 16'd1});
            chk("R5", "bytes read", n_rd, 7);
            chk("R5", "master acks", n_mack, 6);
        end else begin
            chk(abs_e ? "R6" : "R7", "ids not loaded", {svid, sid}, 0);
            chk(abs_e ? "R6" : "R7", "cfg not loaded", {16'b0, cfa, cfb}, 0);
            chk(abs_e ? "R6" : "R7", "no strobes", id_pulses + cf_pulses, 0);
            if (inv_e) begin
                chk("R7", "bytes read", n_rd, 1);
                chk("R7", "header acked", n_mack, 0);
            end
        end
        chk("R8", "strobe outside done", bad_pulse, 0);
        starts_then = n_start; svid_then = svid;
        repeat (200) @(negedge clk);
        chk("R9", "no new bus activity", n_start, starts_then);
        chk("R9", "bus idle", {30'b0, scl, sda_oe}, 32'b10);
        chk("R9", "outputs held", {16'b0, svid}, {16'b0, svid_then});
        chk("R9", "status exclusive", {31'b0, absent & invalid}, 0);
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 190000; wd++) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        run_case(1'b1, BNK, 1'b1);          // success
        run_case(1'b0, BNK, 1'b1);          // R6 no device
        run_case(1'b1, BNK ^ 3'b101, 1'b1); // R6 wrong bank
        run_case(1'b1, BNK, 1'b0);          // R7 bad signature
        for (int k = 0; k < 8; k++) begin
            bit p, h, b;
            p = ($urandom % 4) != 0;
            h = ($urandom % 3) != 0;
            b = ($urandom % 4) == 0;
            run_case(p, b ? 3'(($urandom % 7) + 1) : BNK, h);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule